// File: doc/BRIEF.md
# Semaphore-Gated Descriptor Chain Sequencer

This block is the control engine of one DMA channel. It walks a linked chain of command descriptors held in memory and moves no payload itself. Each descriptor is fetched word by word over a simple read request/acknowledge port. The engine then hands the command to an external data mover with a one-cycle execute pulse and waits for that mover's done handshake before it retires the command.

Software first loads the address of the first command. It then writes a count into the channel's hardware semaphore. The channel runs while the semaphore is non-zero. A retired command lowers the count by one when its decrement flag is set. When its chain flag is set, the channel follows the next-command address stored inside it. A semaphore write always adds to the live count, so further commands can be queued while the channel runs. A clear input returns the channel to idle. A halt input freezes all progress and keeps the in-flight command.

Top module: `dchain_seq`

## Requirements
- R1: After `rst`, or one cycle after `chan_clr`, `sem_count` is 0, `busy` is 0, `rd_req` is 0, and no execute or completion pulse is issued. `chan_clr` wins over a semaphore write in the same cycle.
- R2: A semaphore write adds `sem_wdata` to the live count, whether the channel is idle or running. A sum above 255 saturates at 255. `sem_count` always shows the live value.
- R3: The channel starts a fetch only when the count is non-zero and a command address is loaded. Writing 0 to an idle, empty semaphore starts nothing.
- R4: A descriptor is three 32-bit words at A, A+4 and A+8, holding the next-command address, the control word and the buffer address in that order. Once all three are read, `exec_pulse` is high for exactly one cycle, and `exec_ctrl`/`exec_buf` carry the control and buffer words from then until the next command.
- R5: The first clock edge that sees `exec_done` (or a done held from earlier) with no halt raises `cmd_done` for one cycle. `cmd_irq` rises with it exactly when control bit 3 is set.
- R6: On retirement the count drops by one if control bit 6 is set, and is left unchanged if it is clear.
- R7: When a retired command has control bit 2 set and the count is still non-zero, the next descriptor is fetched from that command's next-command address. When the count reaches zero, the channel stops.
- R8: After a command with control bit 2 clear, the channel goes idle and issues no further read even with a non-zero count, until a new command address is written.
- R9: When a semaphore write and a decrementing retirement fall in the same cycle, both take effect.
- R10: While `halt` is high, no read is issued, no execute pulse is issued and no command retires. A done seen during the halt is kept. After the halt is released, the same command retires.
- R11: `rd_req` stays high with `rd_addr` unchanged until a cycle where `rd_ack` is high (unless halted or cleared). A word transfers on each clock edge where `rd_req` and `rd_ack` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_clr | input | 1 | Channel clear: returns to idle with count 0 |
| halt | input | 1 | Freeze: holds all progress while high |
| ptr_we | input | 1 | Load the first-command address (accepted only while idle) |
| ptr_wdata | input | 32 | First-command address |
| sem_we | input | 1 | Semaphore add strobe |
| sem_wdata | input | 8 | Value added to the semaphore |
| sem_count | output | 8 | Live semaphore count |
| busy | output | 1 | Channel is fetching, issuing or waiting on a command |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid with it |
| rd_data | input | 32 | Read data |
| exec_pulse | output | 1 | One-cycle command issue strobe to the data mover |
| exec_ctrl | output | 32 | Control word of the issued command |
| exec_buf | output | 32 | Buffer address of the issued command |
| exec_done | input | 1 | Data mover finished the issued command |
| cmd_done | output | 1 | One-cycle command retirement strobe |
| cmd_irq | output | 1 | Retirement of a command whose interrupt flag is set |

## Verification
Two things can land on the semaphore in the same cycle: a software add and the decrement from a retiring command. The bench's data mover raises `exec_done` and the add strobe on the same falling edge, while a two-command chain starts with a count of one. Only an engine that applies both the add and the decrement runs the second command and ends with a count of one. A lost add stops the chain after the first command, and a lost decrement leaves a count of two.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  // descriptor layout: word index inside one descriptor
  localparam int DESC_WORDS = 3;
  localparam int IDX_NEXT   = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_BUF    = 2;

  // control word flag positions
  localparam int BIT_CHAIN  = 2;
  localparam int BIT_IRQ    = 3;
  localparam int BIT_DEC    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/dchain_sem.sv
module dchain_sem #(
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [SEM_W-1:0] add_val,
  input  logic             dec,
  output logic [SEM_W-1:0] count
);
  localparam logic [SEM_W:0] SAT = {1'b0, {SEM_W{1'b1}}};

  logic [SEM_W:0] sum_up;
  logic [SEM_W:0] sum_dn;
  logic [SEM_W-1:0] nxt;

  always_comb begin
    sum_up = {1'b0, count} + (add_en ? {1'b0, add_val} : '0);
    sum_dn = (dec && sum_up != '0) ? sum_up - 1'b1 : sum_up;
    nxt    = (sum_dn > SAT) ? SAT[SEM_W-1:0] : sum_dn[SEM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= nxt;
  end

endmodule

// File: rtl/dchain_fetch.sv
module dchain_fetch #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 halt,
  input  logic                 start,
  input  logic [AW-1:0]        base,
  output logic                 rd_req,
  output logic [AW-1:0]        rd_addr,
  input  logic                 rd_ack,
  input  logic [DW-1:0]        rd_data,
  output logic [NW-1:0][DW-1:0] words,
  output logic                 fetched
);
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);
  localparam logic [AW-1:0] STRIDE = AW'(DW / 8);

  logic          active;
  logic [IW-1:0] widx;
  logic          xfer;

  assign xfer = rd_req && rd_ack;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active  <= 1'b0;
      widx    <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      fetched <= 1'b0;
    end else begin
      fetched <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        widx    <= '0;
        rd_addr <= base;
        rd_req  <= !halt;
      end else if (active) begin
        if (xfer) begin
          if (widx == LAST) begin
            active  <= 1'b0;
            rd_req  <= 1'b0;
            fetched <= 1'b1;
          end else begin
            widx    <= widx + 1'b1;
            rd_addr <= rd_addr + STRIDE;
            rd_req  <= !halt;
          end
        end else begin
          rd_req <= !halt;
        end
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clr)
        words[g] <= '0;
      else if (active && xfer && widx == IW'(g))
        words[g] <= rd_data;
    end
  end

endmodule

// File: rtl/dchain_ctl.sv
module dchain_ctl
  import dchain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         halt,
  input  logic                         sem_nz,
  input  logic                         ptr_we,
  input  logic [AW-1:0]                ptr_wdata,
  output logic                         fetch_start,
  output logic [AW-1:0]                fetch_base,
  input  logic                         fetched,
  input  logic [DESC_WORDS-1:0][DW-1:0] words,
  output logic                         exec_pulse,
  output logic [DW-1:0]                exec_ctrl,
  output logic [DW-1:0]                exec_buf,
  input  logic                         exec_done,
  output logic                         cmd_done,
  output logic                         cmd_irq,
  output logic                         sem_dec,
  output logic                         busy
);
  seq_state_t    state;
  logic [AW-1:0] ptr;
  logic          ptr_valid;
  logic          done_lat;
  logic          retire;

  always_comb begin
    fetch_start = (state == ST_IDLE) && !halt && sem_nz && ptr_valid && !ptr_we;
    fetch_base  = ptr;
    retire      = (state == ST_WAIT) && (exec_done || done_lat) && !halt;
    sem_dec     = retire && exec_ctrl[BIT_DEC];
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      ptr_valid  <= 1'b0;
      done_lat   <= 1'b0;
      exec_pulse <= 1'b0;
      exec_ctrl  <= '0;
      exec_buf   <= '0;
      cmd_done   <= 1'b0;
      cmd_irq    <= 1'b0;
    end else begin
      exec_pulse <= 1'b0;
      cmd_done   <= 1'b0;
      cmd_irq    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ptr_we) begin
            ptr       <= ptr_wdata;
            ptr_valid <= 1'b1;
          end else if (fetch_start) begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetched) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (!halt) begin
            exec_pulse <= 1'b1;
            exec_ctrl  <= words[IDX_CTRL];
            exec_buf   <= words[IDX_BUF];
            done_lat   <= 1'b0;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (retire) begin
            cmd_done <= 1'b1;
            cmd_irq  <= exec_ctrl[BIT_IRQ];
            done_lat <= 1'b0;
            if (exec_ctrl[BIT_CHAIN]) ptr <= words[IDX_NEXT][AW-1:0];
            else                      ptr_valid <= 1'b0;
            state <= ST_IDLE;
          end else if (exec_done) begin
            done_lat <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_clr,
  input  logic             halt,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             sem_we,
  input  logic [SEM_W-1:0] sem_wdata,
  output logic [SEM_W-1:0] sem_count,
  output logic             busy,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [DW-1:0]    rd_data,
  output logic             exec_pulse,
  output logic [DW-1:0]    exec_ctrl,
  output logic [DW-1:0]    exec_buf,
  input  logic             exec_done,
  output logic             cmd_done,
  output logic             cmd_irq
);
  logic                          fetch_start;
  logic [AW-1:0]                 fetch_base;
  logic                          fetched;
  logic [DESC_WORDS-1:0][DW-1:0] words;
  logic                          sem_dec;
  logic                          sem_nz;

  assign sem_nz = (sem_count != '0);

  dchain_sem #(.SEM_W(SEM_W)) u_sem (
    .clk(clk), .rst(rst), .clr(chan_clr),
    .add_en(sem_we), .add_val(sem_wdata),
    .dec(sem_dec), .count(sem_count)
  );

  dchain_fetch #(.AW(AW), .DW(DW), .NW(DESC_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .clr(chan_clr), .halt(halt),
    .start(fetch_start), .base(fetch_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .words(words), .fetched(fetched)
  );

  dchain_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .clr(chan_clr), .halt(halt),
    .sem_nz(sem_nz), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .fetch_start(fetch_start), .fetch_base(fetch_base),
    .fetched(fetched), .words(words),
    .exec_pulse(exec_pulse), .exec_ctrl(exec_ctrl), .exec_buf(exec_buf),
    .exec_done(exec_done), .cmd_done(cmd_done), .cmd_irq(cmd_irq),
    .sem_dec(sem_dec), .busy(busy)
  );

endmodule

// File: rtl/dchain_chk.sv
module dchain_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_clr,
  input logic             halt,
  input logic             sem_we,
  input logic [SEM_W-1:0] sem_count,
  input logic             busy,
  input logic             rd_req,
  input logic [AW-1:0]    rd_addr,
  input logic             rd_ack,
  input logic             exec_pulse,
  input logic [DW-1:0]    exec_ctrl,
  input logic             cmd_done
);

  // R1
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    chan_clr |=> (sem_count == '0) && !busy && !rd_req && !exec_pulse && !cmd_done);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(chan_clr) |-> ((SEM_W+1)'(sem_count) + 1'b1) >= (SEM_W+1)'($past(sem_count)));

  // R3
  idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && sem_count == '0) |=> !rd_req);

  // R4
  exec_single_chk: assert property (@(posedge clk) disable iff (rst)
    exec_pulse |=> !exec_pulse);

  // R6
  dec_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && exec_ctrl[6] && !$past(sem_we) && !$past(chan_clr))
      |-> ((SEM_W+1)'(sem_count) + 1'b1) == (SEM_W+1)'($past(sem_count)));

  // R6
  dec_skipped_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !exec_ctrl[6] && !$past(sem_we) && !$past(chan_clr))
      |-> sem_count == $past(sem_count));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !exec_pulse && !cmd_done);

  // R10
  halt_sem_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !sem_we && !chan_clr) |=> $stable(sem_count));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack && !halt && !chan_clr) |=> rd_req && $stable(rd_addr));

endmodule

bind dchain_seq dchain_chk #(.AW(AW), .DW(DW), .SEM_W(SEM_W)) u_chk (
  .clk(clk), .rst(rst), .chan_clr(chan_clr), .halt(halt), .sem_we(sem_we),
  .sem_count(sem_count), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .exec_pulse(exec_pulse), .exec_ctrl(exec_ctrl),
  .cmd_done(cmd_done)
);

// File: tb/sim_dchain_seq.sv
module sim_dchain_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, chan_clr = 1'b0, halt = 1'b0;
  logic        ptr_we = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        t_sem_we = 1'b0, mv_we = 1'b0;
  logic [7:0]  t_sem_wd = '0, mv_wd = '0;
  logic        sem_we;
  logic [7:0]  sem_wdata, sem_count;
  logic        busy, rd_req, rd_ack = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        exec_pulse, exec_done = 1'b0, cmd_done, cmd_irq;
  logic [31:0] exec_ctrl, exec_buf;

  assign sem_we    = t_sem_we | mv_we;
  assign sem_wdata = mv_we ? mv_wd : t_sem_wd;

  dchain_seq u0 (
    .clk(clk), .rst(rst), .chan_clr(chan_clr), .halt(halt),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .sem_we(sem_we), .sem_wdata(sem_wdata), .sem_count(sem_count), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .exec_pulse(exec_pulse), .exec_ctrl(exec_ctrl), .exec_buf(exec_buf),
    .exec_done(exec_done), .cmd_done(cmd_done), .cmd_irq(cmd_irq)
  );

  int n_chk = 0, n_bad = 0;
  int xfer_cnt = 0, done_cnt = 0;
  int mover_lat = 2;
  logic [7:0] wr_on_done = '0;
  logic slow = 1'b0;
  logic [31:0] mem [64];
  logic [31:0] exp_addr[$];
  logic [31:0] exp_buf[$];
  logic        exp_irq[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] ctl, input logic [31:0] bf);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = ctl;
    mem[a/4 + 2] = bf;
  endtask

  // driver side of the scoreboard: expected reads and expected retirements
  task automatic expect_cmd(input logic [31:0] a, input logic [31:0] bf, input bit irq);
    exp_addr.push_back(a);
    exp_addr.push_back(a + 4);
    exp_addr.push_back(a + 8);
    exp_buf.push_back(bf);
    exp_irq.push_back(irq);
  endtask

  task automatic do_ptr(input logic [31:0] a);
    @(negedge clk); ptr_we = 1'b1; ptr_wdata = a;
    @(negedge clk); ptr_we = 1'b0;
  endtask

  task automatic do_sem(input logic [7:0] v);
    @(negedge clk); t_sem_we = 1'b1; t_sem_wd = v;
    @(negedge clk); t_sem_we = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); chan_clr = 1'b1;
    @(negedge clk); chan_clr = 1'b0;
  endtask

  task automatic wait_quiet();
    int idle = 0;
    for (int i = 0; i < 3000 && idle < 5; i++) begin
      @(negedge clk);
      if (!busy && exp_buf.size() == 0) idle++;
      else idle = 0;
    end
  endtask

  // memory responder: checks each read address against the expected queue
  initial begin
    logic phase = 1'b0;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rd_req && (!slow || phase)) begin
        rd_ack  = 1'b1;
        rd_data = mem[rd_addr[7:2]];
        xfer_cnt++;
        if (exp_addr.size() == 0) check(1'b0, "R8 unexpected read", rd_addr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] ea;
          ea = exp_addr.pop_front();
          check(rd_addr == ea, "R4 read address", rd_addr, ea);
        end
      end
      phase = ~phase;
    end
  end

  // data mover model
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      exec_done = 1'b0;
      mv_we     = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          exec_done = 1'b1;
          if (wr_on_done != 0) begin
            mv_we = 1'b1; mv_wd = wr_on_done; wr_on_done = '0;
          end
        end
      end
      if (exec_pulse) cnt = mover_lat;
    end
  end

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_done) begin
        done_cnt++;
        if (exp_buf.size() == 0) check(1'b0, "R5 unexpected completion", exec_buf, 32'hFFFF_FFFF);
        else begin
          logic [31:0] eb;
          logic        ei;
          eb = exp_buf.pop_front();
          ei = exp_irq.pop_front();
          check(exec_buf == eb, "R4 buffer word", exec_buf, eb);
          check(cmd_irq == ei, "R5 irq flag", 32'(cmd_irq), 32'(ei));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int x0, d0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put_desc(32'h00, 32'h10, 32'h44, 32'hA000);
    put_desc(32'h10, 32'h20, 32'h4C, 32'hA100);
    put_desc(32'h20, 32'h00, 32'h40, 32'hA200);
    put_desc(32'h30, 32'h00, 32'h40, 32'hB000);
    put_desc(32'h40, 32'h00, 32'h08, 32'hC000);
    put_desc(32'h50, 32'h60, 32'h44, 32'hD000);
    put_desc(32'h60, 32'h00, 32'h40, 32'hD100);
    put_desc(32'h70, 32'h00, 32'h48, 32'hE000);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sem_count == 0, "R1 reset count", 32'(sem_count), 0);
    check(!busy && !rd_req && !exec_pulse && !cmd_done, "R1 reset idle", 32'(busy), 0);

    // R4 R7 R11: three-command chain with stalled reads
    slow = 1'b1;
    x0 = xfer_cnt;
    expect_cmd(32'h00, 32'hA000, 1'b0);
    expect_cmd(32'h10, 32'hA100, 1'b1);
    expect_cmd(32'h20, 32'hA200, 1'b0);
    do_ptr(32'h00);
    do_sem(8'd3);
    wait_quiet();
    slow = 1'b0;
    check(xfer_cnt - x0 == 9, "R11 word transfers", 32'(xfer_cnt - x0), 9);
    check(sem_count == 0, "R7 count drained", 32'(sem_count), 0);
    check(!busy, "R7 stopped at zero", 32'(busy), 0);

    // R8: unchained command leaves count non-zero and stops
    expect_cmd(32'h30, 32'hB000, 1'b0);
    do_ptr(32'h30);
    do_sem(8'd3);
    wait_quiet();
    x0 = xfer_cnt;
    repeat (10) @(negedge clk);
    check(sem_count == 2, "R8 count left", 32'(sem_count), 2);
    check(xfer_cnt == x0 && !busy, "R8 no further fetch", 32'(xfer_cnt - x0), 0);
    // R1 channel clear
    do_clr();
    check(sem_count == 0 && !busy, "R1 clear count", 32'(sem_count), 0);

    // R6: no decrement flag
    expect_cmd(32'h40, 32'hC000, 1'b1);
    do_ptr(32'h40);
    do_sem(8'd1);
    wait_quiet();
    check(sem_count == 1, "R6 count kept", 32'(sem_count), 1);
    do_clr();

    // R2: add and saturate, no address loaded so nothing runs
    do_sem(8'd200);
    check(sem_count == 200, "R2 add", 32'(sem_count), 200);
    do_sem(8'd100);
    check(sem_count == 255, "R2 saturate", 32'(sem_count), 255);
    check(!busy && !rd_req, "R3 no address no run", 32'(busy), 0);
    // R1 clear wins over simultaneous write
    @(negedge clk); chan_clr = 1'b1; t_sem_we = 1'b1; t_sem_wd = 8'd5;
    @(negedge clk); chan_clr = 1'b0; t_sem_we = 1'b0;
    check(sem_count == 0, "R1 clear over write", 32'(sem_count), 0);

    // R3: zero write starts nothing
    x0 = xfer_cnt;
    do_ptr(32'h00);
    do_sem(8'd0);
    repeat (6) @(negedge clk);
    check(!busy && xfer_cnt == x0, "R3 zero write idle", 32'(xfer_cnt - x0), 0);

    // R9: add and decrement in the same cycle
    expect_cmd(32'h50, 32'hD000, 1'b0);
    expect_cmd(32'h60, 32'hD100, 1'b0);
    do_ptr(32'h50);
    wr_on_done = 8'd2;
    do_sem(8'd1);
    wait_quiet();
    check(sem_count == 1, "R9 add with decrement", 32'(sem_count), 1);
    do_clr();

    // R10: halt before start, then halt while a done arrives
    x0 = xfer_cnt;
    expect_cmd(32'h70, 32'hE000, 1'b1);
    halt = 1'b1;
    do_ptr(32'h70);
    do_sem(8'd1);
    repeat (5) @(negedge clk);
    check(!busy && xfer_cnt == x0, "R10 halted start", 32'(xfer_cnt - x0), 0);
    halt = 1'b0;
    mover_lat = 3;
    for (int i = 0; i < 200 && !exec_pulse; i++) @(negedge clk);
    halt = 1'b1;
    d0 = done_cnt;
    repeat (8) @(negedge clk);
    check(done_cnt == d0, "R10 no retire while halted", 32'(done_cnt - d0), 0);
    check(sem_count == 1, "R10 count held", 32'(sem_count), 1);
    halt = 1'b0;
    wait_quiet();
    check(done_cnt == d0 + 1, "R10 resumed retire", 32'(done_cnt - d0), 1);
    check(sem_count == 0, "R5 R6 final count", 32'(sem_count), 0);
    check(exp_addr.size() == 0, "R4 all reads seen", 32'(exp_addr.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule